// File: doc/BRIEF.md
# Two-Speed Wake Clock Switch

This block picks the system clock after the part leaves sleep. A wake event turns on the internal oscillator at once, so code can run while a crystal on the external pins is still settling. When the external source has been stable for a fixed number of its own periods, the block moves the system clock over to it without a glitch. For external RC and external clock-input modes there is no settling wait, so the move to the external source starts right away. In internal-oscillator modes the external source is never used.

The controller runs on the internal clock. The external clock is treated as a free-running input. A counter in the external domain times the settling period. Each clock enable changes on the falling edge of its own clock. Requests and acknowledgements cross between the two domains through two-flop synchronisers. The new source is turned on only after the old one is confirmed off. The mode is captured on each wake and must stay stable while the part is awake.

Top module: `wake_clk_handover`

## Requirements
- R1: While reset is held, `ext_sel_o`, `int_active_o` and `done_o` are 0 and `sys_clk_o` is low.
- R2: A wake pulse in crystal modes (`mode_i` 0, 1 or 2) turns on the internal source. `int_active_o` is 1 by the falling internal edge that follows the rising edge sampling the wake. `done_o` and `ext_sel_o` stay 0 during the settling wait.
- R3: In crystal modes, `ext_sel_o` does not rise until at least OST_CYCLES external rising edges after the wake. It rises no later than OST_CYCLES+24 such edges.
- R4: The two sources are never enabled together. Once the handover completes, `done_o` is 1 and `int_active_o` is 0.
- R5: In external RC (`mode_i`=3) and external clock-input (`mode_i`=4) modes, no settling count is made. `ext_sel_o` rises within 24 external edges of the wake.
- R6: In internal-oscillator modes (`mode_i` 5 to 7), `done_o` and `int_active_o` are 1 one cycle after the wake. `ext_sel_o` stays 0.
- R7: A further wake during the settling wait restarts the count. The handover then comes at least OST_CYCLES external edges after that last wake.
- R8: A sleep pulse during the settling wait aborts it. All outputs return to 0 by the next falling internal edge, and the external source is never selected.
- R9: A sleep pulse while running on either source returns the block to idle. `done_o` falls and the active enable drops.
- R10: A sleep pulse that arrives while the handover is in flight is held. The handover completes, then the block goes idle, and `done_o` never rises.
- R11: `sys_clk_o` follows the internal clock while `int_active_o` is 1, follows the external clock while `ext_sel_o` is 1, and is low when idle.
- R12: A wake pulse while the block is already running on a source has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator, also the controller clock |
| clk_ext | input | 1 | External oscillator, free running |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Wake pulse, one internal cycle |
| sleep_i | input | 1 | Sleep-entry pulse, one internal cycle |
| mode_i | input | 3 | Clock mode: 0-2 crystal, 3 ext RC, 4 ext clock input, 5-7 internal |
| sys_clk_o | output | 1 | Gated system clock |
| ext_sel_o | output | 1 | External source enabled |
| int_active_o | output | 1 | Status: internal source driving the system |
| done_o | output | 1 | Start-up complete on the final source |

## Verification
Internal-side results fall due at fixed points. The internal enable and the status bit follow half a cycle after the rising edge that samples a wake or sleep. `done_o` in internal modes follows one cycle after the wake. The external handover crosses both domains, so it has a window rather than a single cycle: at least OST_CYCLES external edges after the wake, and at most 24 edges later than that. `done_o` follows the external enable within five internal cycles. The bench counts external edges from the wake, polls once per internal cycle, and checks each result against these windows. Inputs are driven just after falling internal edges. Outputs are sampled two time units after rising internal edges, which never coincide with external edges.

// File: rtl/wake_clk_handover.sv
module wake_clk_handover #(
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk_int,
  input  logic       clk_ext,
  input  logic       rst_n,
  input  logic       wake_i,
  input  logic       sleep_i,
  input  logic [2:0] mode_i,
  output logic       sys_clk_o,
  output logic       ext_sel_o,
  output logic       int_active_o,
  output logic       done_o
);
  localparam int CW = $clog2(OST_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_INT, S_WARM, S_HAND, S_EXT} st_t;
  st_t st;

  logic [2:0] mode_q;
  logic gen_q, pend_q, ext_req_q, run_q, en_int_q;
  logic [1:0] ack_sync, tc_sync, echo_sync;
  logic [1:0] req_sync, gen_sync, run_sync;
  logic gen_seen, tc_q, en_ext_q;
  logic [CW-1:0] cnt;

  wire is_xtal = (mode_q < 3'd3);
  wire ack_s   = ack_sync[1];
  wire tc_ok   = tc_sync[1] && (echo_sync[1] == gen_q);

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode_q    <= '0;
      gen_q     <= 1'b0;
      pend_q    <= 1'b0;
      ext_req_q <= 1'b0;
      run_q     <= 1'b0;
      ack_sync  <= '0;
      tc_sync   <= '0;
      echo_sync <= '0;
    end else begin
      ack_sync  <= {ack_sync[0], en_ext_q};
      tc_sync   <= {tc_sync[0], tc_q};
      echo_sync <= {echo_sync[0], gen_seen};
      ext_req_q <= (st == S_HAND || st == S_EXT) && !en_int_q;
      run_q     <= (st == S_WARM || st == S_HAND || st == S_EXT) && is_xtal;
      case (st)
        S_IDLE: begin
          pend_q <= 1'b0;
          if (wake_i) begin
            mode_q <= mode_i;
            gen_q  <= ~gen_q;
            st     <= (mode_i >= 3'd5) ? S_INT : S_WARM;
          end
        end
        S_INT:  if (sleep_i) st <= S_IDLE;
        S_WARM: begin
          if (sleep_i)                st <= S_IDLE;
          else if (wake_i)            gen_q <= ~gen_q;
          else if (!is_xtal || tc_ok) st <= S_HAND;
        end
        S_HAND: begin
          if (sleep_i) pend_q <= 1'b1;
          if (ack_s)   st <= (pend_q || sleep_i) ? S_IDLE : S_EXT;
        end
        S_EXT:  if (sleep_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) en_int_q <= 1'b0;
    else        en_int_q <= (st == S_INT || st == S_WARM) && !ack_s;
  end

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      gen_sync <= '0;
      run_sync <= '0;
      gen_seen <= 1'b0;
      tc_q     <= 1'b0;
      cnt      <= '0;
    end else begin
      req_sync <= {req_sync[0], ext_req_q};
      gen_sync <= {gen_sync[0], gen_q};
      run_sync <= {run_sync[0], run_q};
      tc_q     <= run_sync[1] && (gen_sync[1] == gen_seen) && (cnt == CW'(OST_CYCLES));
      if (!run_sync[1])                cnt <= '0;
      else if (gen_sync[1] != gen_seen) begin
        if (cnt != '0) cnt <= '0;
        else           gen_seen <= gen_sync[1];
      end
      else if (cnt != CW'(OST_CYCLES)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(negedge clk_ext or negedge rst_n) begin
    if (!rst_n) en_ext_q <= 1'b0;
    else        en_ext_q <= req_sync[1];
  end

  assign sys_clk_o    = (clk_int & en_int_q) | (clk_ext & en_ext_q);
  assign ext_sel_o    = en_ext_q;
  assign int_active_o = en_int_q;
  assign done_o       = (st == S_INT && en_int_q) || st == S_EXT;

  AST_NO_OVERLAP: assert property (@(posedge clk_int) disable iff (!rst_n) !(en_int_q && en_ext_q)); // R4
  AST_WAKE_STARTS_INT: assert property (@(posedge clk_int) disable iff (!rst_n)
    (st == S_IDLE && wake_i && !ack_s) |=> int_active_o); // R2
  AST_EXT_DONE_ACKED: assert property (@(posedge clk_int) disable iff (!rst_n)
    (done_o && !int_active_o) |-> ack_s); // R4
  AST_WARM_ABORT: assert property (@(posedge clk_int) disable iff (!rst_n)
    (st == S_WARM && sleep_i) |=> (st == S_IDLE && !ext_req_q)); // R8
  AST_INTOSC_NO_EXT: assert property (@(posedge clk_int) disable iff (!rst_n)
    (st == S_INT) |-> !ext_req_q); // R6
  AST_CNT_SAT: assert property (@(posedge clk_ext) disable iff (!rst_n)
    cnt <= CW'(OST_CYCLES)); // R3
  AST_IDLE_DARK: assert property (@(posedge clk_int) disable iff (!rst_n)
    (st == S_IDLE && $past(st == S_IDLE)) |-> !int_active_o); // R9
endmodule

// File: tb/wake_clk_handover_bench.sv
module wake_clk_handover_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_HALF   = 6;
  localparam int OST        = 1024;

  logic clk_int = 0, clk_ext = 0, rst_n = 0;
  logic wake_i = 0, sleep_i = 0;
  logic [2:0] mode_i = 0;
  logic sys_clk_o, ext_sel_o, int_active_o, done_o;
  int tests = 0, fails = 0, ext_edges = 0;

  always #(CLK_PERIOD/2) clk_int = ~clk_int;
  always #(EXT_HALF) clk_ext = ~clk_ext;
  always @(posedge clk_ext) ext_edges++;

  wake_clk_handover #(.OST_CYCLES(OST)) u_wake_clk_handover (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n), .wake_i(wake_i),
    .sleep_i(sleep_i), .mode_i(mode_i), .sys_clk_o(sys_clk_o),
    .ext_sel_o(ext_sel_o), .int_active_o(int_active_o), .done_o(done_o));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk_int); #2; endtask
  task automatic pulse_wake; @(negedge clk_int); #1 wake_i = 1; @(negedge clk_int); #1 wake_i = 0; endtask
  task automatic pulse_sleep; @(negedge clk_int); #1 sleep_i = 1; @(negedge clk_int); #1 sleep_i = 0; endtask

  task automatic wait_ext(input int max, output int edges_seen, output bit overlap, output bit early_done);
    int e0 = ext_edges;
    overlap = 0; early_done = 0;
    for (int i = 0; i < max && !ext_sel_o; i++) begin
      tick;
      if (int_active_o && ext_sel_o) overlap = 1;
      if (!ext_sel_o && done_o) early_done = 1;
    end
    edges_seen = ext_edges - e0;
  endtask

  task automatic go_idle(input string req);
    pulse_sleep;
    for (int i = 0; i < 30 && (ext_sel_o || done_o || int_active_o); i++) tick;
    chk(!ext_sel_o && !done_o && !int_active_o, req, "idle after sleep", {ext_sel_o, done_o, int_active_o}, 0);
    repeat (4) tick;
  endtask

  task automatic t_reset;
    repeat (3) tick;
    chk(!ext_sel_o && !int_active_o && !done_o, "R1", "outputs in reset", {ext_sel_o, int_active_o, done_o}, 0);
    chk(sys_clk_o === 1'b0, "R1", "sys_clk in reset", sys_clk_o, 0);
    @(negedge clk_int); #1 rst_n = 1;
    tick;
  endtask

  task automatic t_crystal(input logic [2:0] m);
    int e0, d; bit ov, ed;
    mode_i = m;
    e0 = ext_edges;
    pulse_wake;
    chk(int_active_o && !done_o && !ext_sel_o, "R2", "internal first", {int_active_o, done_o, ext_sel_o}, 3'b100);
    tick;
    chk(sys_clk_o === clk_int, "R11", "sys_clk follows internal", sys_clk_o, clk_int);
    wait_ext(3000, d, ov, ed);
    d = ext_edges - e0;
    chk(d >= OST && d <= OST + 24, "R3", "settling edges", d, OST);
    chk(!ov, "R4", "no overlap during handover", ov, 0);
    chk(!ed, "R2", "done held low while settling", ed, 0);
    repeat (5) tick;
    chk(done_o && !int_active_o && ext_sel_o, "R4", "handover complete", {done_o, int_active_o, ext_sel_o}, 3'b101);
    chk(sys_clk_o === clk_ext, "R11", "sys_clk follows external", sys_clk_o, clk_ext);
    go_idle("R9");
    chk(sys_clk_o === 1'b0, "R11", "sys_clk low when idle", sys_clk_o, 0);
  endtask

  task automatic t_skip(input logic [2:0] m);
    int e0, d; bit ov, ed;
    mode_i = m;
    e0 = ext_edges;
    pulse_wake;
    wait_ext(40, d, ov, ed);
    d = ext_edges - e0;
    chk(ext_sel_o && d <= 24, "R5", "no settling wait", d, 24);
    chk(!ov, "R4", "no overlap fast handover", ov, 0);
    repeat (5) tick;
    chk(done_o && !int_active_o, "R4", "done on external", {done_o, int_active_o}, 2'b10);
    go_idle("R9");
  endtask

  task automatic t_intosc(input logic [2:0] m);
    bit bad = 0;
    mode_i = m;
    pulse_wake;
    tick;
    chk(done_o && int_active_o && !ext_sel_o, "R6", "internal mode ready", {done_o, int_active_o, ext_sel_o}, 3'b110);
    for (int i = 0; i < 40; i++) begin tick; if (ext_sel_o || !done_o) bad = 1; end
    chk(!bad, "R6", "stays on internal", bad, 0);
    pulse_sleep;
    chk(!done_o && !int_active_o, "R9", "internal run stops", {done_o, int_active_o}, 0);
    repeat (4) tick;
  endtask

  task automatic t_restart;
    int e0, d; bit ov, ed;
    mode_i = 3'd1;
    pulse_wake;
    repeat (500) tick;
    chk(!ext_sel_o, "R7", "still settling before restart", ext_sel_o, 0);
    e0 = ext_edges;
    pulse_wake;
    wait_ext(3000, d, ov, ed);
    d = ext_edges - e0;
    chk(d >= OST && d <= OST + 30, "R7", "count restarted", d, OST);
    repeat (5) tick;
    go_idle("R9");
  endtask

  task automatic t_abort;
    bit seen = 0;
    mode_i = 3'd2;
    pulse_wake;
    repeat (300) tick;
    pulse_sleep;
    chk(!done_o && !int_active_o && !ext_sel_o, "R8", "abort to idle", {done_o, int_active_o, ext_sel_o}, 0);
    for (int i = 0; i < 1500; i++) begin tick; if (ext_sel_o || int_active_o) seen = 1; end
    chk(!seen, "R8", "no late handover", seen, 0);
  endtask

  task automatic t_hand_sleep;
    bit saw_ext = 0, saw_done = 0;
    mode_i = 3'd4;
    pulse_wake;
    @(negedge clk_int);
    pulse_sleep;
    for (int i = 0; i < 40; i++) begin
      tick;
      if (ext_sel_o) saw_ext = 1;
      if (done_o) saw_done = 1;
    end
    chk(saw_ext, "R10", "handover completed", saw_ext, 1);
    chk(!saw_done, "R10", "done never rose", saw_done, 0);
    chk(!ext_sel_o && !int_active_o, "R10", "idle after held sleep", {ext_sel_o, int_active_o}, 0);
    repeat (4) tick;
  endtask

  task automatic t_wake_ignored;
    int d; bit ov, ed, bad = 0;
    mode_i = 3'd4;
    pulse_wake;
    wait_ext(40, d, ov, ed);
    repeat (5) tick;
    mode_i = 3'd5;
    pulse_wake;
    for (int i = 0; i < 20; i++) begin tick; if (!ext_sel_o || !done_o || int_active_o) bad = 1; end
    chk(!bad, "R12", "wake ignored on external", bad, 0);
    go_idle("R9");
    bad = 0;
    mode_i = 3'd6;
    pulse_wake;
    tick;
    mode_i = 3'd0;
    pulse_wake;
    for (int i = 0; i < 20; i++) begin tick; if (ext_sel_o || !done_o || !int_active_o) bad = 1; end
    chk(!bad, "R12", "wake ignored on internal", bad, 0);
    go_idle("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_crystal(3'd0);
    t_crystal(3'd2);
    t_skip(3'd3);
    t_skip(3'd4);
    t_intosc(3'd5);
    t_intosc(3'd7);
    t_restart;
    t_abort;
    t_hand_sleep;
    t_wake_ignored;
    t_crystal(3'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule